// File: doc/BRIEF.md
# Grouped Look-Ahead Adder/Subtractor

This block adds or subtracts two 16-bit unsigned or two's-complement operands in a single combinational path. The operand word is split into 4-bit groups. Each group derives a generate term (AND) and a propagate term (OR) for every bit. From those terms and the group's incoming carry, it forms all of its internal carries as flat sum-of-products, so no carry ripples from bit to bit inside a group. Each sum bit is the half-sum (XOR of the operand bits) XORed with the carry entering that bit. The carry leaving one group feeds the next group up.

Subtraction uses the same adder. The B operand is inverted bit by bit, and the carry into the lowest group is forced to one, which yields A minus B modulo 2^16. A surrounding datapath uses the result in the cycle it presents the operands; the block holds no state.

Top module: `hier_cla_adder`

## Requirements
- R1: With `sub_sel` = 0, `{carry_out, result}` equals `op_a + op_b + carry_in` as a 17-bit unsigned sum.
- R2: With `sub_sel` = 1, `result` equals `op_a - op_b` modulo 2^16, and the value on `carry_in` has no effect on either output.
- R3: With `sub_sel` = 1, `carry_out` is 1 exactly when `op_a >= op_b` as unsigned numbers (no borrow), and 0 otherwise.
- R4: The carry leaving each 4-bit group equals the carry out of bit 4g+3 of the full addition, so a carry generated in a low group reaches every higher group (for example, `0x0FFF + 1` gives `0x1000`, and `0xFFFF + 0` with `carry_in` = 1 gives `0x0000` with `carry_out` = 1).
- R5: The outputs depend only on the present inputs. The same inputs always give the same outputs, and all-zero inputs give `result` = 0 and `carry_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand (minuend when subtracting) |
| op_b | input | 16 | Second operand (subtrahend when subtracting) |
| carry_in | input | 1 | Carry into the lowest bit when adding; ignored when subtracting |
| sub_sel | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | 16 | Sum or difference |
| carry_out | output | 1 | Carry out of the top group; in subtraction, 1 means no borrow |

## Verification
The checks take for granted that every input holds a known 0 or 1 at each evaluation and that the word width is a whole number of groups. They compare each group's outgoing carry against the carry recovered from a plain integer sum. The bench drives only defined values and changes the inputs just after a rising edge. It samples at the following falling edge, so the combinational path has settled before the outputs are read. Subtract-mode vectors repeat with both `carry_in` values, so the effect of the forced low carry is observed directly.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int unsigned DATA_W  = 16;
    localparam int unsigned GROUP_W = 4;

    // Per-bit look-ahead terms carried between stages
    typedef struct packed {
        logic gen;   // both operand bits set
        logic prop;  // at least one operand bit set
        logic half;  // operand bits differ
    } bit_terms_t;

    function automatic bit_terms_t make_terms(input logic a_bit, input logic b_bit);
        bit_terms_t t;
        t.gen  = a_bit & b_bit;
        t.prop = a_bit | b_bit;
        t.half = a_bit ^ b_bit;
        return t;
    endfunction

endpackage

// File: rtl/cla_operand_cond.sv
module cla_operand_cond #(
    parameter int unsigned W = 16
) (
    input  logic         sub_sel,
    input  logic [W-1:0] b_in,
    input  logic         cin_in,
    output logic [W-1:0] b_eff,
    output logic         c0
);
    // Subtraction: invert B and force the low carry
    assign b_eff = sub_sel ? ~b_in : b_in;
    assign c0    = sub_sel | cin_in;
    // when sub_sel is 0, c0 follows cin_in; when 1, it is forced to 1
endmodule

// File: rtl/cla_bit_terms.sv
module cla_bit_terms
    import cla_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic                 [W-1:0] a_in,
    input  logic                 [W-1:0] b_in,
    output bit_terms_t           [W-1:0] terms
);
    for (genvar k = 0; k < W; k++) begin : g_bit
        assign terms[k] = make_terms(a_in[k], b_in[k]);
    end
endmodule

// File: rtl/cla_group.sv
module cla_group
    import cla_pkg::*;
#(
    parameter int unsigned GW = 4
) (
    input  bit_terms_t [GW-1:0] terms,
    input  logic                c_in,
    output logic       [GW-1:0] sum,
    output logic                c_out
);
    // carry[i] enters bit i; carry[GW] leaves the group
    logic [GW:0] carry;
    assign carry[0] = c_in;

    for (genvar i = 0; i < GW; i++) begin : g_carry
        logic cy;
        always_comb begin
            logic prod;
            logic acc;
            acc = 1'b0;
            // one product per generating bit j, through propagates above it
            for (int j = 0; j <= i; j++) begin
                prod = terms[j].gen;
                for (int k = j + 1; k <= i; k++) begin
                    prod = prod & terms[k].prop;
                end
                acc = acc | prod;
            end
            // group carry-in through every propagate up to bit i
            prod = c_in;
            for (int k = 0; k <= i; k++) begin
                prod = prod & terms[k].prop;
            end
            cy = acc | prod;
        end
        assign carry[i+1] = cy;
    end

    for (genvar i = 0; i < GW; i++) begin : g_sum
        assign sum[i] = terms[i].half ^ carry[i];
    end

    assign c_out = carry[GW];
endmodule

// File: rtl/hier_cla_adder.sv
module hier_cla_adder #(
    parameter int unsigned DATA_W  = cla_pkg::DATA_W,
    parameter int unsigned GROUP_W = cla_pkg::GROUP_W
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              carry_in,
    input  logic              sub_sel,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);
    localparam int unsigned NUM_GRP = DATA_W / GROUP_W;

    logic [DATA_W-1:0]              b_eff;
    logic                           c0;
    cla_pkg::bit_terms_t [DATA_W-1:0] terms;
    logic [NUM_GRP:0]               chain;
    logic [NUM_GRP-1:0]             grp_cout;

    cla_operand_cond #(.W(DATA_W)) cond_i (
        .sub_sel (sub_sel),
        .b_in    (op_b),
        .cin_in  (carry_in),
        .b_eff   (b_eff),
        .c0      (c0)
    );

    cla_bit_terms #(.W(DATA_W)) terms_i (
        .a_in  (op_a),
        .b_in  (b_eff),
        .terms (terms)
    );

    assign chain[0] = c0;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        cla_group #(.GW(GROUP_W)) grp_i (
            .terms (terms[g*GROUP_W +: GROUP_W]),
            .c_in  (chain[g]),
            .sum   (result[g*GROUP_W +: GROUP_W]),
            .c_out (chain[g+1])
        );
    end

    assign grp_cout  = chain[NUM_GRP:1];
    assign carry_out = chain[NUM_GRP];
endmodule

// File: rtl/hier_cla_adder_chk.sv
module hier_cla_adder_chk #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned GROUP_W = 4
) (
    input logic [DATA_W-1:0]           op_a,
    input logic [DATA_W-1:0]           op_b,
    input logic                        carry_in,
    input logic                        sub_sel,
    input logic [DATA_W-1:0]           result,
    input logic                        carry_out,
    input logic [DATA_W/GROUP_W-1:0]   grp_cout
);
    localparam int unsigned NUM_GRP = DATA_W / GROUP_W;

    logic [DATA_W:0] add_ref;
    logic [DATA_W:0] sub_ref;
    logic [DATA_W:0] bit_carry;

    always_comb begin
        add_ref = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, carry_in};
        sub_ref = {1'b0, op_a} + {1'b0, ~op_b} + {{DATA_W{1'b0}}, 1'b1};
        bit_carry = sub_sel
            ? ({1'b0, op_a} ^ {1'b0, ~op_b} ^ sub_ref)
            : ({1'b0, op_a} ^ {1'b0, op_b} ^ add_ref);

        if (!sub_sel) begin
            a_r1_add_sum: assert ({carry_out, result} == add_ref)
                else $error("R1 sum mismatch");
        end else begin
            a_r2_sub_diff: assert (result == op_a - op_b)
                else $error("R2 difference mismatch");
            a_r3_no_borrow: assert (carry_out == (op_a >= op_b))
                else $error("R3 borrow mismatch");
        end

        for (int g = 0; g < NUM_GRP; g++) begin
            a_r4_group_carry: assert (grp_cout[g] == bit_carry[GROUP_W*(g+1)])
                else $error("R4 group carry mismatch");
        end
    end
endmodule

bind hier_cla_adder hier_cla_adder_chk #(
    .DATA_W  (DATA_W),
    .GROUP_W (GROUP_W)
) chk_i (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sub_sel   (sub_sel),
    .result    (result),
    .carry_out (carry_out),
    .grp_cout  (grp_cout)
);

// File: tb/hier_cla_adder_tb_top.sv
module hier_cla_adder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic        sub_sel = 1'b0;
    logic [15:0] result;
    logic        carry_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    hier_cla_adder dut_i (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sub_sel   (sub_sel),
        .result    (result),
        .carry_out (carry_out)
    );

    // {a, b, cin, sub, expected sum, expected carry}
    localparam int NV = 16;
    localparam logic [50:0] VEC [NV] = '{
        {16'hFFFF, 16'h0001, 1'b0, 1'b0, 16'h0000, 1'b1},  // R1 all-ones + 1
        {16'h0000, 16'h0001, 1'b0, 1'b1, 16'hFFFF, 1'b0},  // R2/R3 0 - 1
        {16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 16'hFFFE, 1'b1},  // R1 max + max
        {16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 16'hFFFF, 1'b1},  // R1 max + max + 1
        {16'h1234, 16'h4321, 1'b0, 1'b0, 16'h5555, 1'b0},  // R1
        {16'h0FFF, 16'h0001, 1'b0, 1'b0, 16'h1000, 1'b0},  // R4 three groups
        {16'h00FF, 16'h0001, 1'b0, 1'b0, 16'h0100, 1'b0},  // R4
        {16'h7FFF, 16'h0001, 1'b0, 1'b0, 16'h8000, 1'b0},  // R4
        {16'h5555, 16'h5555, 1'b0, 1'b1, 16'h0000, 1'b1},  // R3 equal
        {16'h8000, 16'h0001, 1'b0, 1'b1, 16'h7FFF, 1'b1},  // R2/R3
        {16'h0003, 16'h0005, 1'b0, 1'b1, 16'hFFFE, 1'b0},  // R2/R3 borrow
        {16'h0003, 16'h0005, 1'b1, 1'b1, 16'hFFFE, 1'b0},  // R2 carry_in ignored
        {16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0001, 1'b0},  // R1 carry_in only
        {16'hFFFF, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b1},  // R4 full propagate
        {16'hAAAA, 16'h5555, 1'b0, 1'b0, 16'hFFFF, 1'b0},  // R1
        {16'hAAAA, 16'h5555, 1'b1, 1'b0, 16'h0000, 1'b1}   // R4
    };

    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic ci, input logic sb);
        @(posedge clk);
        #1;
        op_a = a; op_b = b; carry_in = ci; sub_sel = sb;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] exp_s, input logic exp_c);
        n_run++;
        if (result !== exp_s || carry_out !== exp_c) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h cin=%b sub=%b: got %h/%b expected %h/%b",
                     req, op_a, op_b, carry_in, sub_sel, result, carry_out, exp_s, exp_c);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R5: all-zero inputs
        apply(16'h0000, 16'h0000, 1'b0, 1'b0);
        check("R5", 16'h0000, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][50:35], VEC[i][34:19], VEC[i][18], VEC[i][17]);
            check("R1/R2/R3/R4 vector", VEC[i][16:1], VEC[i][0]);
        end

        // R2: carry_in toggled under subtraction, result unchanged
        for (int i = 0; i < 40; i++) begin
            logic [15:0] a, b;
            logic [16:0] ref_v;
            a = 16'($urandom);
            b = 16'($urandom);
            ref_v = {1'b0, a} + {1'b0, ~b} + 17'd1;
            apply(a, b, 1'b0, 1'b1);
            check("R2 sub cin0", ref_v[15:0], (a >= b));
            apply(a, b, 1'b1, 1'b1);
            check("R2 sub cin1", ref_v[15:0], (a >= b));  // R3 no-borrow
        end

        // R1 random additions
        for (int i = 0; i < 200; i++) begin
            logic [15:0] a, b;
            logic        ci;
            logic [16:0] ref_v;
            a = 16'($urandom);
            b = 16'($urandom);
            ci = 1'($urandom);
            ref_v = {1'b0, a} + {1'b0, b} + {16'd0, ci};
            apply(a, b, ci, 1'b0);
            check("R1 random add", ref_v[15:0], ref_v[16]);
        end

        // R5: repeating the same inputs gives the same outputs
        apply(16'h1234, 16'h4321, 1'b0, 1'b0);
        apply(16'h1234, 16'h4321, 1'b0, 1'b0);
        check("R5 repeat", 16'h5555, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule